// File: doc/BRIEF.md
# Processor I/O Port and Reset Front End

This block sits between an 8-bit processor core and the system bus. It holds the processor's on-chip parallel port. The port has two local registers. A direction register sits at address 0x0000 and an output latch at address 0x0001. Every other core access passes straight through to the system bus.

The block also does three control jobs. It allows the core to advance only while the bus is granted to it. It presents the interrupt lines to the core in the polarity the core expects, and turns the non-maskable line into an edge event. After reset it fetches the 16-bit start vector from the system bus and hands it to the core's program counter.

Three port bits drive the memory decoder as banking controls: bit 0 as the low-ROM enable, bit 1 as the high-ROM enable and bit 2 as the character/I/O select. A pin whose direction bit is 0 floats high, so after reset all three controls read 1.

Top module: `cpuio_front`

## Requirements
- R1: A core write to address 0x0000 in a step cycle loads the 8-bit direction register. A core read of 0x0000 returns it on `core_rdata` in the same cycle.
- R2: A core write to 0x0001 in a step cycle loads the 8-bit output latch. A core read of 0x0001 returns `port_in | ~direction` in the same cycle.
- R3: Each `port_out` bit equals the latch bit where the direction bit is 1, and is 1 where the direction bit is 0. `ctl_loram`, `ctl_hiram` and `ctl_charen` equal `port_out` bits 0, 1 and 2.
- R4: For any address other than 0x0000 and 0x0001, a core access in a step cycle appears in the same cycle on the system bus: `sys_addr`, `sys_wdata`, `sys_rd` and `sys_wr`. A read returns `sys_rdata` on `core_rdata`.
- R5: Core reads and writes of 0x0000 and 0x0001 never raise `sys_rd` or `sys_wr`.
- R6: `core_step` is high exactly when `aec` is high and the boot sequence has finished. `core_rdy` follows `ba` in the same cycle. Core accesses in cycles without `core_step` reach neither the port registers nor the system bus.
- R7: `core_irq` is the inverse of `irq_n`, registered with one clock of latency.
- R8: A clock edge that samples `nmi_n` low, after the previous edge sampled it high, sets `core_nmi` from the next cycle on. `core_nmi` stays set until the end of a cycle with `core_step` high. A held low level does not set it again.
- R9: A synchronous reset (`rst` high) sets the direction register and the latch to 0xFF, so `port_out` reads 0xFF. It also clears `core_irq` and `core_nmi`.
- R10: Count the cycles after `rst` falls from 0. Cycles 0 to 4 are idle. Cycle 5 reads the system bus at 0xFFFC (low byte). Cycle 6 reads 0xFFFD and raises `core_pc_load`, with `core_pc_val = {high byte, low byte}`. `core_step` may first go high in cycle 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_addr | input | 16 | Core address |
| core_wdata | input | 8 | Core write data |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_rdata | output | 8 | Read data returned to the core |
| core_step | output | 1 | Core may advance one step this cycle |
| core_rdy | output | 1 | Core ready input, follows ba |
| core_irq | output | 1 | Active-high level interrupt to the core |
| core_nmi | output | 1 | Latched non-maskable request to the core |
| core_pc_load | output | 1 | Load the program counter from core_pc_val |
| core_pc_val | output | 16 | Start vector from the system bus |
| sys_addr | output | 16 | System bus address |
| sys_wdata | output | 8 | System bus write data |
| sys_rdata | input | 8 | System bus read data |
| sys_rd | output | 1 | System bus read strobe |
| sys_wr | output | 1 | System bus write strobe |
| port_in | input | 8 | Port input pins |
| port_out | output | 8 | Port output pins |
| ctl_loram | output | 1 | Low-ROM banking control (port bit 0) |
| ctl_hiram | output | 1 | High-ROM banking control (port bit 1) |
| ctl_charen | output | 1 | Character/I/O select (port bit 2) |
| aec | input | 1 | Bus granted to the processor |
| ba | input | 1 | Bus available |
| irq_n | input | 1 | Active-low interrupt request |
| nmi_n | input | 1 | Active-low non-maskable interrupt |

## Verification
The hardest case to reach is an NMI that falls while the core cannot step, and is still pending several cycles later. Two things are tested in that case. First, the request must not be lost. Second, the low level that is still present must not re-arm the request once a step has consumed it. The bench gets there by holding `aec` low across the falling edge and for an extra cycle. It then allows exactly one step cycle and keeps `nmi_n` low afterwards to confirm the request stays cleared. The start-vector fetch is timed by counting cycles from reset release, and this count is repeated with a second vector value.

// File: rtl/cpuio_pkg.sv
package cpuio_pkg;
  typedef enum logic [1:0] {
    PH_WAIT,
    PH_VLO,
    PH_VHI,
    PH_RUN
  } boot_ph_e;
endpackage

// File: rtl/cpuio_port_regs.sv
module cpuio_port_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_dir,
  input  logic          wr_lat,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] lat_q,
  output logic [DW-1:0] pout,
  output logic [DW-1:0] rd_lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '1;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_lat) lat_q <= wdata;
    end
  end

  // Undriven pins float high; driven pins follow the latch.
  for (genvar i = 0; i < DW; i++) begin : g_pin
    assign pout[i] = dir_q[i] ? lat_q[i] : 1'b1;
  end

  assign rd_lat = pin | ~dir_q;
endmodule

// File: rtl/cpuio_intr.sv
module cpuio_intr (
  input  logic clk,
  input  logic rst,
  input  logic irq_n,
  input  logic nmi_n,
  input  logic step,
  output logic irq,
  output logic nmi
);
  logic nmi_prev_q;
  logic nmi_edge;

  assign nmi_edge = nmi_prev_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      nmi        <= 1'b0;
      nmi_prev_q <= 1'b1;
    end else begin
      irq        <= ~irq_n;
      nmi_prev_q <= nmi_n;
      if (nmi_edge)  nmi <= 1'b1;
      else if (step) nmi <= 1'b0;
    end
  end
endmodule

// File: rtl/cpuio_boot.sv
module cpuio_boot
  import cpuio_pkg::*;
#(
  parameter int             AW     = 16,
  parameter int             DW     = 8,
  parameter int             DELAY  = 6,
  parameter logic [AW-1:0]  VEC_LO = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sys_rdata,
  output boot_ph_e      phase,
  output logic [AW-1:0] boot_addr,
  output logic [AW-1:0] pc_val
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [DW-1:0] lo_q;

  always_comb begin
    if (done_q)                 phase = PH_RUN;
    else if (cnt_q == CW'(1))   phase = PH_VLO;
    else if (cnt_q == CW'(0))   phase = PH_VHI;
    else                        phase = PH_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CW'(DELAY);
      done_q <= 1'b0;
      lo_q   <= '0;
    end else if (!done_q) begin
      if (cnt_q != CW'(0)) cnt_q <= cnt_q - CW'(1);
      else                 done_q <= 1'b1;
      if (phase == PH_VLO) lo_q <= sys_rdata;
    end
  end

  assign boot_addr = (phase == PH_VHI) ? VEC_LO + AW'(1) : VEC_LO;
  assign pc_val    = AW'({sys_rdata, lo_q});
endmodule

// File: rtl/cpuio_front.sv
module cpuio_front
  import cpuio_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 8,
  parameter logic [AW-1:0] DIR_ADDR   = 16'h0000,
  parameter logic [AW-1:0] LAT_ADDR   = 16'h0001,
  parameter int            BOOT_DELAY = 6,
  parameter logic [AW-1:0] VEC_LO     = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_rd,
  input  logic          core_wr,
  output logic [DW-1:0] core_rdata,
  output logic          core_step,
  output logic          core_rdy,
  output logic          core_irq,
  output logic          core_nmi,
  output logic          core_pc_load,
  output logic [AW-1:0] core_pc_val,
  output logic [AW-1:0] sys_addr,
  output logic [DW-1:0] sys_wdata,
  input  logic [DW-1:0] sys_rdata,
  output logic          sys_rd,
  output logic          sys_wr,
  input  logic [DW-1:0] port_in,
  output logic [DW-1:0] port_out,
  output logic          ctl_loram,
  output logic          ctl_hiram,
  output logic          ctl_charen,
  input  logic          aec,
  input  logic          ba,
  input  logic          irq_n,
  input  logic          nmi_n
);
  localparam int LORAM_BIT  = 0;
  localparam int HIRAM_BIT  = 1;
  localparam int CHAREN_BIT = 2;

  boot_ph_e      phase;
  logic [AW-1:0] boot_addr;
  logic [DW-1:0] dir_q;
  logic [DW-1:0] lat_q;
  logic [DW-1:0] rd_lat;
  logic          hit_dir;
  logic          hit_lat;
  logic          hit_local;
  logic          boot_rd;

  assign hit_dir   = (core_addr == DIR_ADDR);
  assign hit_lat   = (core_addr == LAT_ADDR);
  assign hit_local = hit_dir | hit_lat;

  assign core_step    = aec & (phase == PH_RUN);
  assign core_rdy     = ba;
  assign boot_rd      = (phase == PH_VLO) | (phase == PH_VHI);
  assign core_pc_load = (phase == PH_VHI);

  assign sys_addr  = boot_rd ? boot_addr : core_addr;
  assign sys_wdata = core_wdata;
  assign sys_rd    = boot_rd | (core_step & core_rd & ~hit_local);
  assign sys_wr    = core_step & core_wr & ~hit_local;

  always_comb begin
    if (hit_dir)      core_rdata = dir_q;
    else if (hit_lat) core_rdata = rd_lat;
    else              core_rdata = sys_rdata;
  end

  cpuio_port_regs #(.DW(DW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_dir (core_step & core_wr & hit_dir),
    .wr_lat (core_step & core_wr & hit_lat),
    .wdata  (core_wdata),
    .pin    (port_in),
    .dir_q  (dir_q),
    .lat_q  (lat_q),
    .pout   (port_out),
    .rd_lat (rd_lat)
  );

  assign ctl_loram  = port_out[LORAM_BIT];
  assign ctl_hiram  = port_out[HIRAM_BIT];
  assign ctl_charen = port_out[CHAREN_BIT];

  cpuio_intr u_intr (
    .clk   (clk),
    .rst   (rst),
    .irq_n (irq_n),
    .nmi_n (nmi_n),
    .step  (core_step),
    .irq   (core_irq),
    .nmi   (core_nmi)
  );

  cpuio_boot #(
    .AW     (AW),
    .DW     (DW),
    .DELAY  (BOOT_DELAY),
    .VEC_LO (VEC_LO)
  ) u_boot (
    .clk       (clk),
    .rst       (rst),
    .sys_rdata (sys_rdata),
    .phase     (phase),
    .boot_addr (boot_addr),
    .pc_val    (core_pc_val)
  );
endmodule

// File: rtl/cpuio_front_chk.sv
module cpuio_front_chk #(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] DIR_ADDR = 16'h0000,
  parameter logic [AW-1:0] LAT_ADDR = 16'h0001,
  parameter logic [AW-1:0] VEC_LO   = 16'hFFFC
) (
  input logic          clk,
  input logic          rst,
  input logic          aec,
  input logic          nmi_n,
  input logic          core_step,
  input logic          core_nmi,
  input logic          core_rd,
  input logic [AW-1:0] core_addr,
  input logic [DW-1:0] core_rdata,
  input logic [DW-1:0] port_in,
  input logic [DW-1:0] dir_q,
  input logic          sys_wr,
  input logic          sys_rd,
  input logic [AW-1:0] sys_addr,
  input logic          core_pc_load
);
  assert_step_needs_aec_R6: assert property (@(posedge clk) disable iff (rst)
    core_step |-> aec);

  assert_local_no_bus_R5: assert property (@(posedge clk) disable iff (rst)
    sys_wr |-> (sys_addr != DIR_ADDR && sys_addr != LAT_ADDR));

  assert_nmi_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |=> core_nmi);

  assert_latch_read_R2: assert property (@(posedge clk) disable iff (rst)
    (core_step && core_rd && core_addr == LAT_ADDR) |-> core_rdata == (port_in | ~dir_q));

  assert_vector_hi_R10: assert property (@(posedge clk) disable iff (rst)
    core_pc_load |-> (sys_rd && sys_addr == VEC_LO + AW'(1) && !core_step));
endmodule

bind cpuio_front cpuio_front_chk #(
  .AW       (AW),
  .DW       (DW),
  .DIR_ADDR (DIR_ADDR),
  .LAT_ADDR (LAT_ADDR),
  .VEC_LO   (VEC_LO)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .aec          (aec),
  .nmi_n        (nmi_n),
  .core_step    (core_step),
  .core_nmi     (core_nmi),
  .core_rd      (core_rd),
  .core_addr    (core_addr),
  .core_rdata   (core_rdata),
  .port_in      (port_in),
  .dir_q        (dir_q),
  .sys_wr       (sys_wr),
  .sys_rd       (sys_rd),
  .sys_addr     (sys_addr),
  .core_pc_load (core_pc_load)
);

// File: tb/sim_cpuio_front.sv
`timescale 1ns/100ps
module sim_cpuio_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] core_addr = '0;
  logic [7:0]  core_wdata = '0;
  logic        core_rd = 1'b0;
  logic        core_wr = 1'b0;
  logic [7:0]  core_rdata;
  logic        core_step, core_rdy, core_irq, core_nmi, core_pc_load;
  logic [15:0] core_pc_val;
  logic [15:0] sys_addr;
  logic [7:0]  sys_wdata;
  logic [7:0]  sys_rdata;
  logic        sys_rd, sys_wr;
  logic [7:0]  port_in = 8'h00;
  logic [7:0]  port_out;
  logic        ctl_loram, ctl_hiram, ctl_charen;
  logic        aec = 1'b1;
  logic        ba = 1'b1;
  logic        irq_n = 1'b1;
  logic        nmi_n = 1'b1;
  logic [7:0]  vec_lo = 8'h34;
  logic [7:0]  vec_hi = 8'h12;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  // System memory model
  always_comb begin
    if (sys_addr == 16'hFFFC)      sys_rdata = vec_lo;
    else if (sys_addr == 16'hFFFD) sys_rdata = vec_hi;
    else                           sys_rdata = sys_addr[7:0] ^ sys_addr[15:8];
  end

  cpuio_front u0 (
    .clk(clk), .rst(rst),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rd(core_rd), .core_wr(core_wr),
    .core_rdata(core_rdata), .core_step(core_step), .core_rdy(core_rdy),
    .core_irq(core_irq), .core_nmi(core_nmi), .core_pc_load(core_pc_load),
    .core_pc_val(core_pc_val), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_rdata(sys_rdata), .sys_rd(sys_rd), .sys_wr(sys_wr),
    .port_in(port_in), .port_out(port_out),
    .ctl_loram(ctl_loram), .ctl_hiram(ctl_hiram), .ctl_charen(ctl_charen),
    .aec(aec), .ba(ba), .irq_n(irq_n), .nmi_n(nmi_n)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    core_addr = a; core_wdata = d; core_wr = 1'b1;
    @(negedge clk);
    core_wr = 1'b0;
  endtask

  task automatic cpu_rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    core_addr = a; core_rd = 1'b1;
    #1 chk(tag, {8'h00, core_rdata}, {8'h00, exp});
    @(negedge clk);
    core_rd = 1'b0;
  endtask

  // R9 reset state, R10 vector fetch timing, R6 step enable after boot
  task automatic t_boot(input logic [7:0] lo, input logic [7:0] hi);
    vec_lo = lo; vec_hi = hi; aec = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 port_out in reset", {8'h00, port_out}, 16'h00FF);
    chk("R3 ctl bits in reset", {13'd0, ctl_charen, ctl_hiram, ctl_loram}, 16'h0007);
    chk("R9 irq/nmi in reset", {14'd0, core_irq, core_nmi}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk($sformatf("R10 sys_rd cyc%0d", k), {15'd0, sys_rd}, {15'd0, (k == 5 || k == 6)});
      chk($sformatf("R10 pc_load cyc%0d", k), {15'd0, core_pc_load}, {15'd0, k == 6});
      chk($sformatf("R6 step cyc%0d", k), {15'd0, core_step}, {15'd0, k == 7});
      if (k == 5) chk("R10 lo vector addr", sys_addr, 16'hFFFC);
      if (k == 6) begin
        chk("R10 hi vector addr", sys_addr, 16'hFFFD);
        chk("R10 pc value", core_pc_val, {hi, lo});
      end
      @(negedge clk);
    end
    cpu_rd_chk("R9 dir after reset", 16'h0000, 8'hFF);
  endtask

  task automatic t_dir();
    cpu_wr(16'h0000, 8'h00);
    cpu_rd_chk("R1 dir read 00", 16'h0000, 8'h00);
    #1 chk("R3 all inputs float high", {8'h00, port_out}, 16'h00FF);
    cpu_wr(16'h0000, 8'h5A);
    cpu_rd_chk("R1 dir read 5A", 16'h0000, 8'h5A);
  endtask

  task automatic t_latch();
    cpu_wr(16'h0000, 8'h0F);
    cpu_wr(16'h0001, 8'h05);
    port_in = 8'h30;
    cpu_rd_chk("R2 latch read mixed dir", 16'h0001, 8'hF0);
    #1;
    chk("R3 port_out mixed dir", {8'h00, port_out}, 16'h00F5);
    chk("R3 loram/hiram/charen", {13'd0, ctl_charen, ctl_hiram, ctl_loram}, 16'h0005);
    cpu_wr(16'h0000, 8'hFF);
    port_in = 8'hA6;
    cpu_rd_chk("R2 latch read all out", 16'h0001, 8'hA6);
    #1 chk("R3 port_out all out", {8'h00, port_out}, 16'h0005);
  endtask

  task automatic t_forward();
    core_addr = 16'h1234; core_wdata = 8'h77; core_wr = 1'b1;
    #1;
    chk("R4 sys_wr", {15'd0, sys_wr}, 16'h0001);
    chk("R4 sys_addr", sys_addr, 16'h1234);
    chk("R4 sys_wdata", {8'h00, sys_wdata}, 16'h0077);
    @(negedge clk);
    core_wr = 1'b0;
    core_addr = 16'hA002; core_rd = 1'b1;
    #1;
    chk("R4 sys_rd", {15'd0, sys_rd}, 16'h0001);
    chk("R4 read data", {8'h00, core_rdata}, 16'h00A2);
    @(negedge clk);
    core_rd = 1'b0;
    cpu_rd_chk("R4 addr 0002 forwarded", 16'h0002, 8'h02);
  endtask

  task automatic t_local();
    core_addr = 16'h0000; core_wdata = 8'hFF; core_wr = 1'b1;
    #1 chk("R5 no sys_wr at 0000", {15'd0, sys_wr}, 16'h0000);
    @(negedge clk);
    core_addr = 16'h0001; core_wdata = 8'h07;
    #1 chk("R5 no sys_wr at 0001", {15'd0, sys_wr}, 16'h0000);
    @(negedge clk);
    core_wr = 1'b0;
    core_rd = 1'b1;
    #1 chk("R5 no sys_rd at 0001", {15'd0, sys_rd}, 16'h0000);
    @(negedge clk);
    core_rd = 1'b0;
  endtask

  task automatic t_gate();
    aec = 1'b0; ba = 1'b0;
    #1;
    chk("R6 no step with aec low", {15'd0, core_step}, 16'h0000);
    chk("R6 rdy follows ba low", {15'd0, core_rdy}, 16'h0000);
    ba = 1'b1;
    #1 chk("R6 rdy follows ba high", {15'd0, core_rdy}, 16'h0001);
    @(negedge clk);
    cpu_wr(16'h0000, 8'h11);
    core_addr = 16'h2000; core_wr = 1'b1;
    #1 chk("R6 no bus write without step", {15'd0, sys_wr}, 16'h0000);
    @(negedge clk);
    core_wr = 1'b0;
    aec = 1'b1;
    cpu_rd_chk("R6 gated dir write ignored", 16'h0000, 8'hFF);
  endtask

  task automatic t_irq();
    irq_n = 1'b0;
    #1 chk("R7 irq not yet", {15'd0, core_irq}, 16'h0000);
    @(negedge clk);
    #1 chk("R7 irq asserted", {15'd0, core_irq}, 16'h0001);
    irq_n = 1'b1;
    @(negedge clk);
    #1 chk("R7 irq released", {15'd0, core_irq}, 16'h0000);
  endtask

  task automatic t_nmi();
    aec = 1'b0; nmi_n = 1'b1;
    @(negedge clk);
    nmi_n = 1'b0;
    @(negedge clk);
    #1 chk("R8 nmi set on fall", {15'd0, core_nmi}, 16'h0001);
    @(negedge clk);
    #1 chk("R8 nmi held without step", {15'd0, core_nmi}, 16'h0001);
    aec = 1'b1;
    @(negedge clk);
    aec = 1'b0;
    #1 chk("R8 nmi cleared by step", {15'd0, core_nmi}, 16'h0000);
    @(negedge clk);
    #1 chk("R8 low level no retrigger", {15'd0, core_nmi}, 16'h0000);
    nmi_n = 1'b1;
    @(negedge clk);
    nmi_n = 1'b0;
    @(negedge clk);
    #1 chk("R8 second fall", {15'd0, core_nmi}, 16'h0001);
    nmi_n = 1'b1; aec = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_boot(8'h34, 8'h12);
    t_dir();
    t_latch();
    t_forward();
    t_local();
    t_gate();
    t_irq();
    t_nmi();
    t_boot(8'hEF, 8'hBE);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #20000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule